// File: doc/BRIEF.md
# Double-Buffered Dual-Channel DAC Register Controller

This block sits behind a two-wire serial bus receiver and turns its stream of received bytes into settings for a pair of 8-bit DAC channels. After the receiver reports an address match, the bytes alternate between a command byte and an output byte. The command byte carries a channel select, a power-down request and a clear request. The output byte that follows carries the new code for the selected channel.

Every write lands first in a per-channel staging register, called the input latch. The codes seen by the analog stage, held in the output latches, and the power-down state change only when a STOP arrives while this device is addressed. Both channels can therefore move at the same instant. A transfer that is abandoned, for example by a repeated START that selects another device, leaves its staged data waiting. That data is applied by the next transfer to this device that carries at least one command byte.

Top module: `dac_pair_ctrl`

## Requirements
- R1: After reset both output codes are 0x00, all input latches are 0x00 and `outEnable` is 1 (not powered down).
- R2: In a command byte, bit 0 selects the channel, bit 3 is the power-down request and bit 4 is the clear request. Bits 7..5 and 2..1 have no effect.
- R3: An output byte that follows a command byte is written to the input latch of the channel chosen by that command's bit 0. The output codes do not change until a STOP arrives while `addressed` is high. At that STOP both channels are copied from their input latches in the same cycle.
- R4: A command byte with bit 4 set clears every input latch, and the output byte that follows it is discarded. Later command/output pairs in the same transfer write the input latches normally.
- R5: At a committing STOP, `outEnable` becomes the inverse of bit 3 of the last command byte received in that transfer. It changes at no other time.
- R6: While powered down, output codes still update at a committing STOP. A later transfer whose last command has bit 3 clear sets `outEnable` to 1, and the output codes then show the output-latch contents.
- R7: A command byte that is cut short by a STOP has no effect. An output byte that is cut short by a STOP is discarded, but its command's power-down and clear requests still take effect.
- R8: A STOP with `addressed` low changes nothing, and any staged data is kept. A STOP with no completed command byte in the transfer does not copy the latches. The next transfer that has at least one command byte and then a STOP copies the staged data.
- R9: Each address match makes the next accepted byte a command byte. Bytes that arrive while `addressed` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset, asynchronous |
| addrMatch | input | 1 | One-cycle pulse: the slave address matched and a transfer starts |
| addressed | input | 1 | High while this device is the target of the current transfer |
| byteValid | input | 1 | One-cycle pulse: a complete byte is on `byteData` |
| byteData | input | 8 | Received byte |
| stopSeen | input | 1 | One-cycle pulse: STOP condition detected |
| outCodes | output | NUM_CH*DATA_W | Output-latch codes, with channel 0 in the low byte |
| outEnable | output | 1 | 1 = analog outputs driven, 0 = powered down (outputs float) |

## Verification
The embedded assertions check on every cycle that the output latches and the power-down flag change only at a committing STOP, and that a clear request zeroes the input latches. They also check that an address match resets the byte phase and that input latches are written only while the device is addressed. Some behaviours appear only in the bench's scenarios: last-command-wins power-down, the discarded byte after a clear, early STOPs, and staged data that survives a repeated START to another device. The bench shows these through the output codes and `outEnable`, comparing them against a reference model driven by random and directed transfers.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  typedef enum logic {PH_CMD = 1'b0, PH_OUT = 1'b1} phase_t;

  typedef struct packed {
    logic loadIn;  // write selected input latch
    logic clrIn;   // clear all input latches
    logic commit;  // copy input latches to output latches
    logic chSel;   // target channel of loadIn
  } strobes_t;

  localparam int SEL_BIT = 0;
  localparam int PD_BIT  = 3;
  localparam int CLR_BIT = 4;
endpackage

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrMatch,
  input  logic              addressed,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopSeen,
  output strobes_t          strobes,
  output logic              pdActive
);
  phase_t phase;
  logic   gotCmd, skipNext, selReg, pendPd, pdReg;
  logic   cmdAccept, outAccept, cmdSel;

  assign cmdAccept = byteValid && addressed && !addrMatch && (phase == PH_CMD);
  assign outAccept = byteValid && addressed && !addrMatch && (phase == PH_OUT);

  generate
    if (NUM_CH == 1) begin : g_single
      assign cmdSel = 1'b0;
    end else begin : g_dual
      assign cmdSel = byteData[SEL_BIT];
    end
  endgenerate

  always_comb begin
    strobes.loadIn = outAccept && !skipNext;
    strobes.clrIn  = cmdAccept && byteData[CLR_BIT];
    strobes.commit = stopSeen && addressed && gotCmd;
    strobes.chSel  = selReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_CMD;
      gotCmd   <= 1'b0;
      skipNext <= 1'b0;
      selReg   <= 1'b0;
      pendPd   <= 1'b0;
      pdReg    <= 1'b0;
    end else begin
      if (addrMatch) begin
        phase    <= PH_CMD;
        gotCmd   <= 1'b0;
        skipNext <= 1'b0;
      end else if (cmdAccept) begin
        phase    <= PH_OUT;
        gotCmd   <= 1'b1;
        skipNext <= byteData[CLR_BIT];
        selReg   <= cmdSel;
        pendPd   <= byteData[PD_BIT];
      end else if (outAccept) begin
        phase    <= PH_CMD;
        skipNext <= 1'b0;
      end
      if (strobes.commit) begin
        pdReg  <= pendPd;
        gotCmd <= 1'b0;
      end
    end
  end

  assign pdActive = pdReg;

  AST_PD_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(pdActive)); // R5
  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    addrMatch |=> (phase == PH_CMD) && !gotCmd); // R9
  AST_WRITE_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadIn || strobes.clrIn) |-> addressed); // R9
endmodule

// File: rtl/dacc_datapath.sv
module dacc_datapath
  import dacc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobes_t                 strobes,
  input  logic [DATA_W-1:0]        wrData,
  output logic [NUM_CH*DATA_W-1:0] outCodes
);
  logic [NUM_CH*DATA_W-1:0] inFlat;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [DATA_W-1:0] inLatch, outLatch;
    logic hit;
    assign hit = strobes.loadIn && ((NUM_CH == 1) || (strobes.chSel == 1'(g)));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inLatch  <= '0;
        outLatch <= '0;
      end else begin
        if (strobes.clrIn)   inLatch <= '0;
        else if (hit)        inLatch <= wrData;
        if (strobes.commit)  outLatch <= inLatch;
      end
    end

    assign inFlat[g*DATA_W +: DATA_W]   = inLatch;
    assign outCodes[g*DATA_W +: DATA_W] = outLatch;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(outCodes)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrIn |=> (inFlat == '0)); // R4
endmodule

// File: rtl/dac_pair_ctrl.sv
module dac_pair_ctrl
  import dacc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     addrMatch,
  input  logic                     addressed,
  input  logic                     byteValid,
  input  logic [DATA_W-1:0]        byteData,
  input  logic                     stopSeen,
  output logic [NUM_CH*DATA_W-1:0] outCodes,
  output logic                     outEnable
);
  strobes_t strobes;
  logic     pdActive;

  dacc_ctrl #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .addrMatch(addrMatch), .addressed(addressed),
    .byteValid(byteValid), .byteData(byteData), .stopSeen(stopSeen),
    .strobes(strobes), .pdActive(pdActive)
  );

  dacc_datapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(byteData),
    .outCodes(outCodes)
  );

  assign outEnable = !pdActive;
endmodule

// File: tb/dac_pair_ctrl_tb_top.sv
module dac_pair_ctrl_tb_top;
  logic clk = 0, rstN = 0;
  logic addrMatch = 0, addressed = 0, byteValid = 0, stopSeen = 0;
  logic [7:0] byteData = 0;
  logic [15:0] outCodes;
  logic outEnable;
  int total = 0, bad = 0;

  // reference state, built from the requirements
  logic [7:0] mIn [2];
  logic [7:0] mOut [2];
  logic mPd, mPhOut, mGot, mSkip, mSel, mPend;

  always #2 clk = ~clk;

  dac_pair_ctrl dut_i (.clk(clk), .rstN(rstN), .addrMatch(addrMatch),
    .addressed(addressed), .byteValid(byteValid), .byteData(byteData),
    .stopSeen(stopSeen), .outCodes(outCodes), .outEnable(outEnable));

  function automatic logic [16:0] expVal();
    return {~mPd, mOut[1], mOut[0]};
  endfunction

  task automatic chk(string tag);
    total++;
    if ({outEnable, outCodes} !== expVal()) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, {outEnable, outCodes}, expVal());
    end
  endtask

  task automatic sendAddr();
    addrMatch = 1; addressed = 1;
    @(negedge clk); addrMatch = 0;
    mPhOut = 0; mGot = 0; mSkip = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    byteValid = 1; byteData = b;
    @(negedge clk); byteValid = 0;
    if (addressed) begin
      if (!mPhOut) begin
        mPhOut = 1; mGot = 1; mSel = b[0]; mPend = b[3]; mSkip = b[4];
        if (b[4]) begin mIn[0] = 0; mIn[1] = 0; end
      end else begin
        mPhOut = 0;
        if (!mSkip) mIn[mSel] = b;
        mSkip = 0;
      end
    end
  endtask

  task automatic sendStop();
    stopSeen = 1;
    @(negedge clk); stopSeen = 0;
    if (addressed && mGot) begin
      mOut[0] = mIn[0]; mOut[1] = mIn[1]; mPd = mPend; mGot = 0;
    end
    addressed = 0;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    mIn[0] = 0; mIn[1] = 0; mOut[0] = 0; mOut[1] = 0;
    mPd = 0; mPhOut = 0; mGot = 0; mSkip = 0; mSel = 0; mPend = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset");

    // R3: both channels staged, outputs wait for STOP
    sendAddr(); sendByte(8'h00); sendByte(8'hA5); sendByte(8'h01); sendByte(8'h3C);
    chk("R3 before stop");
    sendStop(); chk("R3 simultaneous");

    // R2: reserved and don't-care bits set, no effect
    sendAddr(); sendByte(8'hE7 & ~8'h18); sendByte(8'h77); sendStop();
    chk("R2 ignored bits");

    // R4: clear, skipped byte, later pair writes
    sendAddr(); sendByte(8'h10); sendByte(8'hFF); sendByte(8'h01); sendByte(8'h42);
    chk("R4 before stop"); sendStop(); chk("R4 clear and skip");

    // R5: last command decides power-down
    sendAddr(); sendByte(8'h08); sendByte(8'h11); sendByte(8'h01); sendByte(8'h22); sendStop();
    chk("R5 pd off by last cmd");
    sendAddr(); sendByte(8'h00); sendByte(8'h33); sendByte(8'h08); sendStop();
    chk("R5 pd by last cmd alone");

    // R6: latches update while powered down, then restore
    sendAddr(); sendByte(8'h09); sendByte(8'h99); sendStop(); chk("R6 update in pd");
    sendAddr(); sendByte(8'h00); sendStop(); chk("R6 restore");

    // R7: stop inside command byte (no byte strobe) -> nothing
    sendAddr(); sendByte(8'h00); sendByte(8'h5A); sendStop();
    sendAddr(); sendStop(); chk("R7 interrupted cmd");
    // R7: stop inside output byte -> command's pd/clr applied
    sendAddr(); sendByte(8'h18); sendStop(); chk("R7 interrupted out");
    sendAddr(); sendByte(8'h00); sendStop(); chk("R7 wake");

    // R8: repeated start to another device, stop while not addressed
    sendAddr(); sendByte(8'h00); sendByte(8'hC3); addressed = 0;
    sendByte(8'h01); sendByte(8'hEE); sendStop(); chk("R8 stop ignored");
    sendAddr(); sendStop(); chk("R8 no cmd no copy");
    sendAddr(); sendByte(8'h01); sendStop(); chk("R8 staged data copied");

    // R9: address match mid-pair restarts phase
    sendAddr(); sendByte(8'h01); sendAddr(); sendByte(8'h00); sendByte(8'h6D); sendStop();
    chk("R9 phase restart");

    // random transfers
    for (int t = 0; t < 400; t++) begin
      sendAddr();
      for (int k = 0, n = $urandom_range(0, 6); k < n; k++) begin
        logic [7:0] b;
        b = 8'($urandom);
        if (($urandom % 4) != 0) b[4] = 0;
        if (($urandom % 2) != 0) b[3] = 0;
        sendByte(b);
      end
      if (($urandom % 8) == 0) addressed = 0;
      sendStop();
      chk("R3 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule